// File: doc/BRIEF.md
# Two-Wire Register Target

This block is a serial target on a two-wire bus (SCL clock, SDA data). It gives a host read and write access to a small file of 8-bit registers. Both bus lines are brought in through synchronizer flops and sampled on a fast system clock. The block never drives SDA high. It only pulls the line low, through an open-drain enable (`sda_oe`), so the pad outside sees `sda_oe = 1` as "drive low".

A host addresses the target with a 7-bit device address. The upper four bits of that address are fixed and the lower three come from strap inputs. After the address, the host sends a register address byte and then any number of data bytes. Reads return data from the current register pointer. The pointer steps after every data byte. It keeps its value across a STOP, so a host can set the pointer in one transaction and read in a later one. The block also drives an interrupt output. Its active level is chosen by a polarity bit held in the last register of the file.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is {4'b1101, strap[2:0]}. In the first byte after a START, bit 0 is R/W, with 0 meaning write and 1 meaning read. When bits 7:1 of that byte match the device address, the target pulls SDA low during the ninth clock (ACK).
- R2: When the address byte does not match, the target gives no ACK. It then ignores the bus until the next START: later bytes get no ACK and no register changes.
- R3: Every byte moves most-significant bit first, in both directions.
- R4: In a write, the second byte is the register address and each following byte is a data byte. Each of these bytes gets an ACK, and each data byte is stored at the current pointer.
- R5: The pointer takes the low ADDR_W bits of the register address byte. It increments by one after every data byte written or read, and wraps modulo 2^ADDR_W.
- R6: A read returns the register at the pointer. It goes on with the next register for as long as the host ACKs. After a host NACK (SDA high in the ninth clock), the target releases SDA and waits for a START or a STOP.
- R7: The pointer is kept across a STOP. A read in a new transaction starts at the register that an earlier pointer-setting write selected.
- R8: A repeated START restarts the address phase from any state, with SDA released.
- R9: A STOP returns the target to idle with SDA released. Bytes clocked after a STOP and without a new START get no ACK.
- R10: Bit 0 of register 2^ADDR_W-1 selects the interrupt polarity. When that bit is 1, `int_o` equals `int_req`. When it is 0, `int_o` equals the inverse of `int_req`. `int_o` is registered, so it follows one clock after its inputs.
- R11: After reset, SDA is released, the pointer is 0, every register reads 0 and `int_o` is 1.
- R12: With straps at 000 the device address is 0x68. Writing 0xAA to register 0x00 and then reading register 0x00 returns 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| strap | input | 3 | Low three bits of the device address |
| int_req | input | 1 | Interrupt request from the surrounding logic |
| int_o | output | 1 | Interrupt output with programmable level |

## Verification
The bench builds the block with the default ADDR_W = 4, a 16-entry register file, and the default two-flop synchronizer. At this size a 16-byte burst crosses the wrap from register 15 back to register 0. The 3-bit strap input is swept through all eight values, each time with one matching address and one near-miss address. Because register 15 is also the polarity register, bursts and direct writes both exercise how the interrupt level follows a register write.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WACK,
        ST_TX,
        ST_HACK
    } tgt_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [6:0] dev_addr(input logic [2:0] strap);
        return {DEV_PREFIX, strap};
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic scl_d;
    logic sda_d;
    logic scl_now;
    logic sda_now;

    // Synchronizer chain: one flop per stage, idle bus level is high.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_q[g] <= 1'b1;
                sda_q[g] <= 1'b1;
            end else if (g == 0) begin
                scl_q[g] <= scl_i;
                sda_q[g] <= sda_i;
            end else begin
                scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_now = scl_q[SYNC_STAGES-1];
    assign sda_now = sda_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_now;
            sda_d <= sda_now;
        end
    end

    always_comb begin
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
        ev.sda      = sda_now;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] ptr,
    output tgt_state_t        state,
    output logic              dev_nomatch
);
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw;
    logic       hack;
    logic       rx_state;
    logic       byte_done;
    logic       addr_hit;

    assign rx_state  = (state == ST_DEV) || (state == ST_REG) || (state == ST_WDATA);
    assign byte_done = rx_state && ev.scl_fall && (cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == dev_addr(strap));

    assign wr_en       = byte_done && (state == ST_WDATA);
    assign wr_data     = shreg;
    assign dev_nomatch = byte_done && (state == ST_DEV) && !addr_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            rw    <= 1'b0;
            ptr   <= '0;
            hack  <= 1'b0;
        end else if (ev.start) begin
            state <= ST_DEV;
            cnt   <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_DEV, ST_REG, ST_WDATA: begin
                    if (ev.scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_DEV) begin
                            if (addr_hit) begin
                                rw    <= shreg[0];
                                state <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_REG) begin
                            ptr   <= shreg[ADDR_W-1:0];
                            state <= ST_REG_ACK;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_WACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            shreg <= rd_data;
                            state <= ST_TX;
                        end else begin
                            state <= ST_REG;
                        end
                    end
                end
                ST_REG_ACK, ST_WACK: begin
                    if (ev.scl_fall) begin
                        cnt   <= '0;
                        state <= ST_WDATA;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt   <= '0;
                            ptr   <= ptr + 1'b1;
                            state <= ST_HACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            cnt   <= cnt + 4'd1;
                        end
                    end
                end
                ST_HACK: begin
                    if (ev.scl_rise) begin
                        hack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (hack) begin
                            shreg <= rd_data;
                            state <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WACK: sda_oe = 1'b1;
            ST_TX:                           sda_oe = ~shreg[7];
            default:                         sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              int_req,
    output logic              int_o,
    output logic              pol
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int CTRL_IDX = DEPTH - 1;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign pol     = mem[CTRL_IDX][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            int_o <= 1'b1;
        end else begin
            int_o <= pol ? int_req : ~int_req;
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       int_req,
    output logic       int_o
);
    bus_ev_t           ev;
    tgt_state_t        state;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] ptr;
    logic              dev_nomatch;
    logic              pol;
    logic              start_det;
    logic              stop_det;

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap       (strap),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ptr         (ptr),
        .state       (state),
        .dev_nomatch (dev_nomatch)
    );

    i2c_tgt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .int_req (int_req),
        .int_o   (int_o),
        .pol     (pol)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input tgt_state_t        state,
    input logic              wr_en,
    input logic [ADDR_W-1:0] ptr,
    input logic              dev_nomatch,
    input logic              pol,
    input logic              int_req,
    input logic              int_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_DEV) && !sda_oe);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr == $past(ptr) + 1'b1);

    // R2
    nomatch_chk: assert property (@(posedge clk) disable iff (rst)
        dev_nomatch |=> !sda_oe && (state == ST_IDLE));

    // R10
    int_pol_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> int_o == ($past(pol) ? $past(int_req) : !$past(int_req)));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .state       (state),
    .wr_en       (wr_en),
    .ptr         (ptr),
    .dev_nomatch (dev_nomatch),
    .pol         (pol),
    .int_req     (int_req),
    .int_o       (int_o)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       int_req = 1'b0;
    logic [2:0] strap = 3'd0;
    logic       sda_oe;
    logic       int_o;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] model [16];

    assign sda_line = sda_h & ~sda_oe;

    always #4 clk = ~clk;

    i2c_reg_target dut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_h),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap   (strap),
        .int_req (int_req),
        .int_o   (int_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q);
            scl_h = 1'b1; tick(2*Q);
            scl_h = 1'b0;
        end
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; tick(Q);
            scl_h = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_h = 1'b0;
        end
        sda_h = nack; tick(Q);
        scl_h = 1'b1; tick(2*Q);
        scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    function automatic logic [7:0] devw(input logic [2:0] s);
        return {4'b1101, s, 1'b0};
    endfunction

    task automatic set_ptr(input logic [2:0] s, input logic [7:0] r);
        logic a;
        bus_start();
        send_byte(devw(s), a);
        send_byte(r, a);
        bus_stop();
    endtask

    task automatic wr_one(input logic [2:0] s, input logic [7:0] r, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(devw(s), a);
        send_byte(r, a);
        send_byte(d, a);
        check("R4 single write data ack", a, 1);
        bus_stop();
        model[r[3:0]] = d;
    endtask

    task automatic rd_one(input logic [2:0] s, input logic [7:0] r, input string tag);
        logic a;
        logic [7:0] v;
        set_ptr(s, r);
        bus_start();
        send_byte(devw(s) | 8'h01, a);
        recv_byte(1'b1, v);
        check(tag, v, model[r[3:0]]);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        logic [6:0] dev;
        logic [7:0] d;
        for (int k = 0; k < 16; k++) model[k] = 8'h00;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R11 reset state
        check("R11 sda_oe after reset", sda_oe, 0);
        check("R11 int_o after reset", int_o, 1);
        rd_one(3'd0, 8'h03, "R11 register reads zero after reset");

        // Strap sweep: matching and near-miss addresses
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            dev = {4'b1101, 3'(s)};
            d = 8'((s * 29 + 3) & 255);
            bus_start();
            send_byte({dev, 1'b0}, a);
            check($sformatf("R1 address ack strap=%0d", s), a, 1);
            send_byte(8'(s), a);
            check("R4 register address ack", a, 1);
            send_byte(d, a);
            check("R4 data ack", a, 1);
            bus_stop();
            model[s] = d;
            tick(2);
            check("R9 sda released after stop", sda_oe, 0);

            bus_start();
            send_byte({((s % 2) == 0) ? (dev ^ 7'h01) : (dev ^ 7'h20), 1'b0}, a);
            check($sformatf("R2 mismatched address no ack strap=%0d", s), a, 0);
            send_byte(8'(s), a);
            check("R2 byte after mismatch no ack", a, 0);
            send_byte(~d, a);
            check("R2 second byte after mismatch no ack", a, 0);
            bus_stop();

            set_ptr(3'(s), 8'(s));
            bus_start();
            send_byte({dev, 1'b1}, a);
            check("R1 read address ack", a, 1);
            recv_byte(1'b1, v);
            check($sformatf("R3 R7 read back reg %0d msb first", s), v, model[s]);
            tick(Q);
            check("R6 sda released after host nack", sda_oe, 0);
            bus_stop();
        end

        // Burst write with wrap, starting at 0xF3 -> register 3
        strap = 3'd5;
        bus_start();
        send_byte(devw(3'd5), a);
        send_byte(8'hF3, a);
        for (int i = 0; i < 16; i++) begin
            d = 8'((i * 53 + 17) & 255);
            send_byte(d, a);
            check($sformatf("R4 burst byte %0d ack", i), a, 1);
            model[(3 + i) & 15] = d;
        end
        bus_stop();

        set_ptr(3'd5, 8'h00);
        bus_start();
        send_byte(devw(3'd5) | 8'h01, a);
        for (int k = 0; k < 16; k++) begin
            recv_byte(k == 15, v);
            check($sformatf("R5 R6 burst read reg %0d", k), v, model[k]);
        end
        bus_stop();

        set_ptr(3'd5, 8'h0F);
        bus_start();
        send_byte(devw(3'd5) | 8'h01, a);
        recv_byte(1'b0, v);
        check("R5 read reg 15", v, model[15]);
        recv_byte(1'b1, v);
        check("R5 read wraps to reg 0", v, model[0]);
        bus_stop();

        // Repeated START: set pointer then read without STOP
        bus_start();
        send_byte(devw(3'd5), a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(devw(3'd5) | 8'h01, a);
        check("R8 address ack after repeated start", a, 1);
        recv_byte(1'b1, v);
        check("R8 read after repeated start", v, model[2]);
        bus_stop();

        // Repeated START between two writes
        bus_start();
        send_byte(devw(3'd5), a);
        send_byte(8'h04, a);
        send_byte(8'h5C, a);
        bus_start();
        send_byte(devw(3'd5), a);
        send_byte(8'h06, a);
        send_byte(8'h3A, a);
        bus_stop();
        model[4] = 8'h5C;
        model[6] = 8'h3A;
        rd_one(3'd5, 8'h04, "R8 first write before repeated start");
        rd_one(3'd5, 8'h06, "R8 second write after repeated start");

        // Bytes after STOP without START are ignored
        scl_h = 1'b0; tick(Q);
        send_byte(devw(3'd5), a);
        check("R9 byte after stop not acked", a, 0);
        bus_stop();

        // Worked example at straps 000
        strap = 3'd0;
        bus_start();
        send_byte(8'hD0, a);
        check("R12 address 0x68 acked", a, 1);
        send_byte(8'h00, a);
        send_byte(8'hAA, a);
        bus_stop();
        model[0] = 8'hAA;
        set_ptr(3'd0, 8'h00);
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(1'b1, v);
        check("R12 read reg 0", v, 8'hAA);
        bus_stop();

        // Interrupt polarity
        wr_one(3'd0, 8'h0F, 8'h01);
        int_req = 1'b1; tick(4);
        check("R10 active-high asserted", int_o, 1);
        int_req = 1'b0; tick(4);
        check("R10 active-high idle", int_o, 0);
        wr_one(3'd0, 8'h0F, 8'h00);
        int_req = 1'b1; tick(4);
        check("R10 active-low asserted", int_o, 0);
        int_req = 1'b0; tick(4);
        check("R10 active-low idle", int_o, 1);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule